// File: doc/BRIEF.md
# Manchester II line repeater

This block takes a Manchester II coded serial line and sends it on again, re-timed to its own sampling clock. The incoming stream arrives either on one non-inverted line or on a differential pair made of a one line and a zero line. A configuration input picks which of the two is used. The block runs from a single oversampling clock at 16 or 32 times the bit rate, chosen by a speed input.

The selected input passes through a two-stage synchroniser and a level decoder. It then runs through a delay line that holds it for half a bit period, which is 8 samples at 16X and 16 samples at 32X. The result leaves on a complementary pair of one and zero outputs. Next to the pair runs a transmit clock at twice the bit rate. That clock restarts its phase at every level change of the retransmitted stream, so its rising edges line up with the data edges.

An active-low clear-to-send input gates all three outputs. While it is high they stay low. Gating only masks the outputs: the delay line and the clock phase keep running, and no preamble or sync pattern is ever inserted. Only received data is repeated.

Top module: `mch_repeater`

## Requirements
- R1: While `rst_n` is low, `tx_one`, `tx_zero` and `tx_clk2x` are all low, and they go low as soon as reset is asserted, without waiting for a clock edge.
- R2: The retransmitted level at the output edge E+HALF+3 equals the decoded input level sampled at edge E. HALF is 8 when `speed_hi` is 0 (16X clock) and 16 when `speed_hi` is 1 (32X clock).
- R3: With `diff_sel` at 0 the decoded level equals `se_in`, and the values on `one_in` and `zero_in` have no effect on any output.
- R4: When enabled, `tx_one` carries the retransmitted level and `tx_zero` carries its complement, so exactly one of the two is high.
- R5: `cts_n` sampled high at an edge forces all three outputs low after that edge. `cts_n` sampled low lets the delayed stream and the clock through unchanged. Toggling `cts_n` never inserts a preamble, a sync or any pattern other than the delayed input.
- R6: The transmit clock phase restarts at each change of the retransmitted level. `tx_clk2x` is high for HALF/2 samples and then low for HALF/2 samples, repeating with period HALF while the level is constant, so it is high at every edge where the data changes.
- R7: With `diff_sel` at 1, `one_in`=1 with `zero_in`=0 decodes as level 1 and `one_in`=0 with `zero_in`=1 decodes as level 0. When both lines are equal the previous decoded level is held. `se_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, 16X or 32X the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_hi | input | 1 | 0 selects 16X oversampling, 1 selects 32X |
| diff_sel | input | 1 | 0 selects the single-ended line, 1 selects the differential pair |
| se_in | input | 1 | Single-ended non-inverted Manchester II input |
| one_in | input | 1 | Differential input, one line |
| zero_in | input | 1 | Differential input, zero line |
| cts_n | input | 1 | Active-low clear-to-send, gates all outputs |
| tx_one | output | 1 | Retransmitted one line |
| tx_zero | output | 1 | Retransmitted zero line |
| tx_clk2x | output | 1 | Transmit clock at twice the bit rate, phase-locked to output data edges |

## Verification
The stream is driven in both speed modes with alternating bits, pseudo-random bits, and long runs of ones and of zeros. The alternating and random bits catch a wrong delay tap or an inverted output. The constant runs show whether the transmit clock free-runs correctly between data edges. In the single-ended segments the unused pair toggles at random, and in the differential segments the single-ended line toggles, which exposes a wrong input select. Differential segments also drive both lines equal on the first sample of some half-bits, which separates holding the previous level from forcing a fixed one. Clear-to-send toggles both during traffic and on an idle line, so any gate that stalls the pipeline or inserts a pattern shows up as a mismatch.

// File: rtl/mch_rep_pkg.sv
package mch_rep_pkg;

    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] se;
        logic [SYNC_STAGES-1:0] one;
        logic [SYNC_STAGES-1:0] zero;
        logic                   lvl;
    } front_st_t;

    // Level decode: single-ended passes straight through; the pair resolves
    // to a level only when its lines disagree, otherwise the old level stays.
    function automatic logic pick_level(input logic use_pair,
                                        input logic se,
                                        input logic one,
                                        input logic zero,
                                        input logic held);
        logic r;
        if (!use_pair)          r = se;
        else if (one && !zero)  r = 1'b1;
        else if (!one && zero)  r = 1'b0;
        else                    r = held;
        return r;
    endfunction

endpackage

// File: rtl/mch_rep_front.sv
module mch_rep_front
    import mch_rep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic diff_sel,
    input  logic se_in,
    input  logic one_in,
    input  logic zero_in,
    output logic lvl_o
);

    front_st_t st_d, st_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_comb begin
                st_d      = st_q;
                st_d.se   = {st_q.se[SYNC_STAGES-2:0],   se_in};
                st_d.one  = {st_q.one[SYNC_STAGES-2:0],  one_in};
                st_d.zero = {st_q.zero[SYNC_STAGES-2:0], zero_in};
                st_d.lvl  = pick_level(diff_sel,
                                       st_q.se[SYNC_STAGES-1],
                                       st_q.one[SYNC_STAGES-1],
                                       st_q.zero[SYNC_STAGES-1],
                                       st_q.lvl);
            end
        end else begin : g_single
            always_comb begin
                st_d      = st_q;
                st_d.se   = se_in;
                st_d.one  = one_in;
                st_d.zero = zero_in;
                st_d.lvl  = pick_level(diff_sel, st_q.se[0], st_q.one[0],
                                       st_q.zero[0], st_q.lvl);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

endmodule

// File: rtl/mch_rep_delay.sv
module mch_rep_delay #(
    parameter int unsigned DEPTH_HI = 16,
    parameter int unsigned DEPTH_LO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_hi,
    input  logic din,
    output logic tap_o
);

    typedef struct packed {
        logic [DEPTH_HI-1:0] taps;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.taps = {st_q.taps[DEPTH_HI-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tap_o = speed_hi ? st_q.taps[DEPTH_HI-1] : st_q.taps[DEPTH_LO-1];

endmodule

// File: rtl/mch_rep_txout.sv
module mch_rep_txout #(
    parameter int unsigned HALF_HI = 16,
    parameter int unsigned HALF_LO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_hi,
    input  logic cts_n,
    input  logic tap_i,
    output logic tx_one,
    output logic tx_zero,
    output logic tx_clk2x
);

    localparam int unsigned PW = $clog2(HALF_HI);

    typedef struct packed {
        logic          lvl;
        logic [PW-1:0] phase;
        logic          one;
        logic          zero;
        logic          ck;
    } tx_st_t;

    tx_st_t st_d, st_q;

    logic [PW-1:0] last_phase;
    logic [PW:0]   high_len;
    logic          en;

    always_comb begin
        last_phase = speed_hi ? PW'(HALF_HI - 1) : PW'(HALF_LO - 1);
        high_len   = speed_hi ? (PW+1)'(HALF_HI / 2) : (PW+1)'(HALF_LO / 2);
        en         = !cts_n;

        st_d     = st_q;
        st_d.lvl = tap_i;
        if (tap_i != st_q.lvl)           st_d.phase = '0;
        else if (st_q.phase >= last_phase) st_d.phase = '0;
        else                             st_d.phase = st_q.phase + 1'b1;

        st_d.one  = en && tap_i;
        st_d.zero = en && !tap_i;
        st_d.ck   = en && ({1'b0, st_d.phase} < high_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_one   = st_q.one;
    assign tx_zero  = st_q.zero;
    assign tx_clk2x = st_q.ck;

endmodule

// File: rtl/mch_repeater.sv
module mch_repeater #(
    parameter int unsigned OVS_LO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_hi,
    input  logic diff_sel,
    input  logic se_in,
    input  logic one_in,
    input  logic zero_in,
    input  logic cts_n,
    output logic tx_one,
    output logic tx_zero,
    output logic tx_clk2x
);

    localparam int unsigned HALF_LO = OVS_LO / 2;
    localparam int unsigned HALF_HI = OVS_LO;

    logic lvl_w;
    logic tap_w;

    mch_rep_front u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .diff_sel (diff_sel),
        .se_in    (se_in),
        .one_in   (one_in),
        .zero_in  (zero_in),
        .lvl_o    (lvl_w)
    );

    mch_rep_delay #(
        .DEPTH_HI (HALF_HI),
        .DEPTH_LO (HALF_LO)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed_hi (speed_hi),
        .din      (lvl_w),
        .tap_o    (tap_w)
    );

    mch_rep_txout #(
        .HALF_HI (HALF_HI),
        .HALF_LO (HALF_LO)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed_hi (speed_hi),
        .cts_n    (cts_n),
        .tap_i    (tap_w),
        .tx_one   (tx_one),
        .tx_zero  (tx_zero),
        .tx_clk2x (tx_clk2x)
    );

endmodule

// File: rtl/mch_rep_chk.sv
module mch_rep_chk (
    input logic clk,
    input logic rst_n,
    input logic cts_n,
    input logic diff_sel,
    input logic one_in,
    input logic zero_in,
    input logic lvl,
    input logic tx_one,
    input logic tx_zero,
    input logic tx_clk2x
);

    // R5: blocked at the previous edge means every output is low now
    p_blocked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cts_n) |-> (!tx_one && !tx_zero && !tx_clk2x));

    // R4: enabled outputs are always complementary
    p_pair_compl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cts_n)) |-> (tx_one != tx_zero));

    // R6: a data change on the line coincides with the clock being high
    p_clk_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(cts_n) && !$past(cts_n, 2)
         && (tx_one != $past(tx_one))) |-> tx_clk2x);

    // R7: equal pair lines leave the decoded level unchanged
    p_pair_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && $past(diff_sel)
         && ($past(one_in, 3) == $past(zero_in, 3))) |-> (lvl == $past(lvl)));

    // R1: while reset is held the outputs read low
    always @(negedge clk) begin
        if (!rst_n) begin
            a_reset_low_r1: assert (!tx_one && !tx_zero && !tx_clk2x);
        end
    end

endmodule

bind mch_repeater mch_rep_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cts_n    (cts_n),
    .diff_sel (diff_sel),
    .one_in   (one_in),
    .zero_in  (zero_in),
    .lvl      (lvl_w),
    .tx_one   (tx_one),
    .tx_zero  (tx_zero),
    .tx_clk2x (tx_clk2x)
);

// File: tb/mch_repeater_test.sv
module mch_repeater_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int OVS_LO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic speed_hi = 1'b0;
    logic diff_sel = 1'b0;
    logic se_in = 1'b0;
    logic one_in = 1'b0;
    logic zero_in = 1'b1;
    logic cts_n = 1'b0;
    logic tx_one, tx_zero, tx_clk2x;

    mch_repeater #(.OVS_LO(OVS_LO)) uut (
        .clk(clk), .rst_n(rst_n), .speed_hi(speed_hi), .diff_sel(diff_sel),
        .se_in(se_in), .one_in(one_in), .zero_in(zero_in), .cts_n(cts_n),
        .tx_one(tx_one), .tx_zero(tx_zero), .tx_clk2x(tx_clk2x)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic lvl;
        logic dif;
    } item_t;

    item_t sb[$];
    item_t cur;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    half_m = OVS_LO / 2;
    int    mphase = 0;
    int    tog_cnt = 0;
    logic  mprev = 1'b0;
    logic  lvl_m = 1'b0;
    logic  last_l = 1'b0;
    logic  last_dif = 1'b0;
    logic  cts_var = 1'b0;
    logic  rst_seen = 1'b0;
    logic  cts_seen = 1'b0;
    logic  e1, e0, ec;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // driver: one sample per call, pushes the expected decoded level
    task automatic tick(input logic l, input logic dif, input logic noise,
                        input logic glitch, input logic cts);
        @(posedge clk);
        #1;
        cts_n    = cts;
        diff_sel = dif;
        se_in    = l;
        one_in   = l;
        zero_in  = ~l;
        if (!dif && noise) begin
            one_in  = lfsr[0];
            zero_in = lfsr[1];
        end
        if (dif && glitch) begin
            one_in  = lfsr[2];
            zero_in = lfsr[2];
        end
        if (dif && noise) se_in = lfsr[3];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!dif)                      lvl_m = se_in;
        else if (one_in && !zero_in)   lvl_m = 1'b1;
        else if (!one_in && zero_in)   lvl_m = 1'b0;
        sb.push_back('{lvl_m, dif});
        last_l   = l;
        last_dif = dif;
    endtask

    task automatic send_bits(input int nbits, input int kind, input logic dif,
                             input logic noise, input logic glitch, input logic cts_tog);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            case (kind)
                0:       b = i[0];
                1:       b = lfsr[7];
                2:       b = 1'b1;
                default: b = 1'b0;
            endcase
            for (int h = 0; h < 2; h++) begin
                for (int s = 0; s < half_m; s++) begin
                    logic l;
                    l = (h == 0) ? b : ~b;
                    if (cts_tog) begin
                        tog_cnt++;
                        if (tog_cnt % 29 == 0) cts_var = ~cts_var;
                    end else begin
                        cts_var = 1'b0;
                    end
                    tick(l, dif, noise, glitch && (s == 0) && lfsr[5], cts_var);
                end
            end
        end
    endtask

    task automatic settle();
        for (int i = 0; i < 4; i++) tick(last_l, last_dif, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic start_mode(input logic hi);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        // R1: reset acts without a clock edge
        chk("R1", "tx_one async", tx_one, 1'b0);
        chk("R1", "tx_zero async", tx_zero, 1'b0);
        chk("R1", "tx_clk2x async", tx_clk2x, 1'b0);
        speed_hi = hi;
        diff_sel = 1'b0;
        se_in    = 1'b0;
        one_in   = 1'b0;
        zero_in  = 1'b1;
        cts_n    = 1'b0;
        half_m   = hi ? OVS_LO : OVS_LO / 2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "tx_one held", tx_one, 1'b0);
        chk("R1", "tx_zero held", tx_zero, 1'b0);
        chk("R1", "tx_clk2x held", tx_clk2x, 1'b0);
        sb.delete();
        for (int i = 0; i < half_m + 3; i++) sb.push_back('{1'b0, 1'b0});
        lvl_m    = 1'b0;
        mprev    = 1'b0;
        mphase   = 0;
        last_l   = 1'b0;
        last_dif = 1'b0;
        cts_var  = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        sb.push_back('{1'b0, 1'b0});
    endtask

    task automatic run_mode(input logic hi);
        start_mode(hi);
        send_bits(24, 0, 1'b0, 1'b1, 1'b0, 1'b0);      // R3 alternating, pair toggling
        settle();
        send_bits(24, 1, 1'b0, 1'b0, 1'b0, 1'b1);      // R5 random with gating
        settle();
        send_bits(24, 1, 1'b1, 1'b1, 1'b1, 1'b0);      // R7 pair with equal-line samples
        settle();
        send_bits(8, 2, 1'b1, 1'b1, 1'b0, 1'b0);       // R6 constant runs
        send_bits(8, 3, 1'b1, 1'b1, 1'b0, 1'b0);
        settle();
        for (int i = 0; i < 80; i++) begin             // R5 idle line, gate toggling
            if (i % 13 == 0) cts_var = ~cts_var;
            tick(last_l, last_dif, 1'b0, 1'b0, cts_var);
        end
        for (int i = 0; i < half_m + 6; i++) tick(last_l, last_dif, 1'b0, 1'b0, 1'b0);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        rst_seen <= rst_n;
        cts_seen <= cts_n;
    end

    always @(negedge clk) begin
        if (rst_seen && rst_n) begin
            if (sb.size() == 0) begin
                chk("R2", "scoreboard empty", 1'b1, 1'b0);
            end else begin
                cur = sb.pop_front();
                if (cur.lvl != mprev)         mphase = 0;
                else if (mphase >= half_m - 1) mphase = 0;
                else                           mphase = mphase + 1;
                mprev = cur.lvl;
                e1 = !cts_seen && cur.lvl;
                e0 = !cts_seen && !cur.lvl;
                ec = !cts_seen && (mphase < half_m / 2);
                if (cts_seen) begin
                    chk("R5", "tx_one gated", tx_one, e1);
                    chk("R5", "tx_zero gated", tx_zero, e0);
                    chk("R5", "tx_clk2x gated", tx_clk2x, ec);
                end else begin
                    chk(cur.dif ? "R2 R4 R7" : "R2 R4 R3", "tx_one", tx_one, e1);
                    chk(cur.dif ? "R2 R4 R7" : "R2 R4 R3", "tx_zero", tx_zero, e0);
                    chk("R6", "tx_clk2x", tx_clk2x, ec);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule